// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block tracks the health of a CAN-style node. It keeps a transmit and a receive error counter, compares them against a host-programmable warning limit, and derives three states from them: error warning, error passive and bus-off. It also holds a one-byte record of a bus error, which stays frozen until the host reads it.

A bit-level protocol engine feeds the block. It sends one-cycle error pulses, each tagged with an error kind, a direction and a frame segment code, and it sends one-cycle pulses for each frame sent or received without error. The block drives status levels, one-cycle interrupt events and a small byte-wide register port. The register port carries the reset-mode control bit, the warning limit, both counters and the captured error byte.

When the transmit counter would pass 255, the node goes bus-off. The transmit counter is then loaded with 128, the receive counter is cleared, and the node is forced into reset mode. The host starts recovery by clearing the reset-mode bit.

Top module: `can_fault_confine`

## Requirements
- R1: After reset the registers read as follows: reset-mode bit 1, warning limit 96, both counters 0, capture byte 0. All status outputs and interrupt outputs are low.
- R2: A transmit error adds 8 to the transmit counter. A receive error adds 1 to the receive counter, saturating at 255. A transmit success subtracts 1 from the transmit counter and a receive success subtracts 1 from the receive counter, neither going below 0. Success pulses are ignored in any cycle that carries an error pulse.
- R3: While `listen_only_i` is high, the receive counter does not change on error or success pulses. The transmit counter still counts.
- R4: A transmit error that would take the transmit counter above 255 enters bus-off. In that case the transmit counter becomes 128, the receive counter becomes 0, `bus_status_o` rises and the reset-mode bit is forced to 1. While bus-off, error and success pulses leave both counters unchanged.
- R5: While bus-off, a host write of 0 to bit 0 of address 0 clears bus-off, clears the transmit counter to 0 and clears the reset-mode bit.
- R6: `err_status_o` is high when either counter is greater than or equal to the warning limit. `err_passive_o` is high when either counter is at least 128.
- R7: `irq_warn_o` is high for one cycle whenever `err_status_o` or `bus_status_o` has changed at the last clock edge. `irq_passive_o` is high for one cycle whenever `err_passive_o` has changed at the last edge.
- R8: An error pulse is captured only while the capture is armed. The capture byte is laid out as bits 7:6 kind (0 bit, 1 form, 2 stuff, 3 other), bit 5 direction (0 transmit, 1 receive) and bits 4:0 segment. A capture disarms the unit and raises `irq_bus_err_o` for one cycle. A read strobe at address 4 re-arms the unit. Later errors neither change the byte nor raise the interrupt until that read.
- R9: Host writes to the warning limit (address 1), receive counter (address 2) and transmit counter (address 3) take effect only while the reset-mode bit is 1; otherwise they are ignored.
- R10: `reg_rdata_o` is combinational from `reg_addr_i`: address 0 gives the reset-mode bit in bit 0, 1 the limit, 2 the receive counter, 3 the transmit counter, 4 the capture byte, and any other address gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | One-cycle bus error event |
| err_kind_i | input | 2 | Error kind: 0 bit, 1 form, 2 stuff, 3 other |
| err_rx_i | input | 1 | Error direction: 1 receive, 0 transmit |
| err_seg_i | input | 5 | Frame segment code of the error |
| tx_ok_i | input | 1 | Frame transmitted without error |
| rx_ok_i | input | 1 | Frame received without error |
| listen_only_i | input | 1 | Listen-only operation, freezes receive counter |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (re-arms capture at address 4) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| reset_mode_o | output | 1 | Reset-mode bit |
| err_status_o | output | 1 | A counter at or above the warning limit |
| bus_status_o | output | 1 | Bus-off |
| err_passive_o | output | 1 | A counter at or above 128 |
| irq_warn_o | output | 1 | Error or bus status changed |
| irq_passive_o | output | 1 | Error-passive state changed |
| irq_bus_err_o | output | 1 | A bus error was captured |

## Verification
Every counter, state and capture update appears one clock edge after the pulse or write that causes it. The status and interrupt outputs reflect the new state in that same cycle. Read data is combinational and shows the state before the edge at which a read strobe acts. The bench therefore checks read data half a cycle before each edge and checks status and interrupt outputs 1 ns after the edge. A cycle-level model in the bench advances in step with these checks. The bench sweeps every counter value against several limits, every kind and direction over the listed segment codes, and a long pseudo-random event mix that passes through bus-off and recovery repeatedly.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned SEG_W  = 5;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXCNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              rx_dir;
    logic [SEG_W-1:0]  seg;
  } cap_t;
endpackage

// File: rtl/fc_counters.sv
module fc_counters
  import fc_pkg::*;
#(
  parameter int unsigned TX_STEP  = 8,
  parameter int unsigned RX_STEP  = 1,
  parameter int unsigned BOFF_TEC = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_v_i,
  input  logic             err_rx_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             listen_only_i,
  input  logic             wr_tec_i,
  input  logic             wr_rec_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             recover_i,
  output logic [REG_W-1:0] tec_o,
  output logic [REG_W-1:0] rec_o,
  output logic             bus_off_o,
  output logic             boff_enter_o
);
  localparam logic [REG_W:0]   TX_INC = (REG_W+1)'(TX_STEP);
  localparam logic [REG_W:0]   RX_INC = (REG_W+1)'(RX_STEP);
  localparam logic [REG_W-1:0] BOFF_V = REG_W'(BOFF_TEC);
  localparam logic [REG_W-1:0] ONE    = REG_W'(1);

  logic [REG_W-1:0] tec_q, rec_q, tec_d, rec_d;
  logic             boff_q, boff_d;
  logic [REG_W:0]   tec_up, rec_up;

  assign tec_up       = {1'b0, tec_q} + TX_INC;
  assign rec_up       = {1'b0, rec_q} + RX_INC;
  assign boff_enter_o = err_v_i & ~err_rx_i & ~boff_q & tec_up[REG_W];

  always_comb begin
    tec_d  = tec_q;
    rec_d  = rec_q;
    boff_d = boff_q;
    if (recover_i) begin
      tec_d  = '0;
      boff_d = 1'b0;
    end else if (boff_enter_o) begin
      tec_d  = BOFF_V;
      rec_d  = '0;
      boff_d = 1'b1;
    end else begin
      if (!boff_q) begin
        if (err_v_i && !err_rx_i)                  tec_d = tec_up[REG_W-1:0];
        else if (!err_v_i && tx_ok_i && tec_q != '0) tec_d = tec_q - ONE;
        if (!listen_only_i) begin
          if (err_v_i && err_rx_i)
            rec_d = rec_up[REG_W] ? {REG_W{1'b1}} : rec_up[REG_W-1:0];
          else if (!err_v_i && rx_ok_i && rec_q != '0)
            rec_d = rec_q - ONE;
        end
      end
      if (wr_tec_i) tec_d = wdata_i;
      if (wr_rec_i) rec_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tec_q  <= '0;
      rec_q  <= '0;
      boff_q <= 1'b0;
    end else begin
      tec_q  <= tec_d;
      rec_q  <= rec_d;
      boff_q <= boff_d;
    end
  end

  assign tec_o     = tec_q;
  assign rec_o     = rec_q;
  assign bus_off_o = boff_q;

  p_busoff_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_off_o) |-> (tec_o == BOFF_V && rec_o == '0));

  p_tx_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_v_i && !err_rx_i && !bus_off_o && !boff_enter_o && !wr_tec_i && !recover_i)
    |=> tec_o == $past(tec_o) + TX_INC[REG_W-1:0]);

  p_rec_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_only_i && !wr_rec_i && !boff_enter_o) |=> $stable(rec_o));

  p_boff_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !recover_i && !wr_tec_i) |=> $stable(tec_o));
endmodule

// File: rtl/fc_capture.sv
module fc_capture
  import fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_v_i,
  input  logic [KIND_W-1:0] err_kind_i,
  input  logic              err_rx_i,
  input  logic [SEG_W-1:0]  err_seg_i,
  input  logic              rearm_i,
  output logic [REG_W-1:0]  cap_o,
  output logic              irq_o
);
  cap_t cap_q;
  logic armed_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q   <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= err_v_i & armed_q;
      if (err_v_i && armed_q) begin
        cap_q.kind   <= err_kind_i;
        cap_q.rx_dir <= err_rx_i;
        cap_q.seg    <= err_seg_i;
        armed_q      <= 1'b0;
      end else if (rearm_i) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  p_cap_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !rearm_i) |=> ($stable(cap_o) && !irq_o));

  p_cap_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_i && !err_v_i) |=> armed_q);
endmodule

// File: rtl/fc_status.sv
module fc_status
  import fc_pkg::*;
#(
  parameter int unsigned PASS_LVL = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] tec_i,
  input  logic [REG_W-1:0] rec_i,
  input  logic [REG_W-1:0] ewl_i,
  input  logic             bus_off_i,
  output logic             err_st_o,
  output logic             passive_o,
  output logic             bus_st_o,
  output logic             irq_warn_o,
  output logic             irq_pass_o
);
  localparam logic [REG_W-1:0] PASS_V = REG_W'(PASS_LVL);

  logic est_q, pas_q, bst_q;

  assign err_st_o  = (tec_i >= ewl_i) | (rec_i >= ewl_i);
  assign passive_o = (tec_i >= PASS_V) | (rec_i >= PASS_V);
  assign bus_st_o  = bus_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q <= 1'b0;
      pas_q <= 1'b0;
      bst_q <= 1'b0;
    end else begin
      est_q <= err_st_o;
      pas_q <= passive_o;
      bst_q <= bus_st_o;
    end
  end

  assign irq_warn_o = (err_st_o ^ est_q) | (bus_st_o ^ bst_q);
  assign irq_pass_o = passive_o ^ pas_q;

  p_pass_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (passive_o != $past(passive_o)) |-> irq_pass_o);

  p_bus_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_st_o != $past(bus_st_o)) |-> irq_warn_o);
endmodule

// File: rtl/fc_regs.sv
module fc_regs
  import fc_pkg::*;
#(
  parameter int unsigned EWL_RST = 96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              boff_enter_i,
  input  logic              bus_off_i,
  input  logic [REG_W-1:0]  tec_i,
  input  logic [REG_W-1:0]  rec_i,
  input  logic [REG_W-1:0]  cap_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              mode_o,
  output logic [REG_W-1:0]  ewl_o,
  output logic              wr_tec_o,
  output logic              wr_rec_o,
  output logic              recover_o,
  output logic              rearm_o
);
  logic             mode_q;
  logic [REG_W-1:0] ewl_q;
  logic             wr_mode, wr_ewl;

  assign wr_mode   = wr_i && (addr_i == A_MODE);
  assign wr_ewl    = wr_i && (addr_i == A_LIMIT) && mode_q;
  assign wr_rec_o  = wr_i && (addr_i == A_RXCNT) && mode_q;
  assign wr_tec_o  = wr_i && (addr_i == A_TXCNT) && mode_q;
  assign recover_o = wr_mode && !wdata_i[0] && bus_off_i;
  assign rearm_o   = rd_i && (addr_i == A_CAPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b1;
      ewl_q  <= REG_W'(EWL_RST);
    end else begin
      if (boff_enter_i)  mode_q <= 1'b1;
      else if (wr_mode)  mode_q <= wdata_i[0];
      if (wr_ewl)        ewl_q  <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_MODE:  rdata_o = {{(REG_W-1){1'b0}}, mode_q};
      A_LIMIT: rdata_o = ewl_q;
      A_RXCNT: rdata_o = rec_i;
      A_TXCNT: rdata_o = tec_i;
      A_CAPT:  rdata_o = cap_i;
      default: rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign ewl_o  = ewl_q;

  p_mode_forced_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boff_enter_i |=> mode_o);

  p_cfg_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |=> $stable(ewl_o));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import fc_pkg::*;
#(
  parameter int unsigned TX_STEP  = 8,
  parameter int unsigned RX_STEP  = 1,
  parameter int unsigned PASS_LVL = 128,
  parameter int unsigned BOFF_TEC = 128,
  parameter int unsigned EWL_RST  = 96
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        err_valid_i,
  input  logic [1:0]  err_kind_i,
  input  logic        err_rx_i,
  input  logic [4:0]  err_seg_i,
  input  logic        tx_ok_i,
  input  logic        rx_ok_i,
  input  logic        listen_only_i,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        reset_mode_o,
  output logic        err_status_o,
  output logic        bus_status_o,
  output logic        err_passive_o,
  output logic        irq_warn_o,
  output logic        irq_passive_o,
  output logic        irq_bus_err_o
);
  logic [REG_W-1:0] tec, rec, ewl, cap;
  logic             bus_off, boff_enter, wr_tec, wr_rec, recover, rearm;

  fc_counters #(
    .TX_STEP (TX_STEP),
    .RX_STEP (RX_STEP),
    .BOFF_TEC(BOFF_TEC)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .err_v_i      (err_valid_i),
    .err_rx_i     (err_rx_i),
    .tx_ok_i      (tx_ok_i),
    .rx_ok_i      (rx_ok_i),
    .listen_only_i(listen_only_i),
    .wr_tec_i     (wr_tec),
    .wr_rec_i     (wr_rec),
    .wdata_i      (reg_wdata_i),
    .recover_i    (recover),
    .tec_o        (tec),
    .rec_o        (rec),
    .bus_off_o    (bus_off),
    .boff_enter_o (boff_enter)
  );

  fc_capture u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_v_i   (err_valid_i),
    .err_kind_i(err_kind_i),
    .err_rx_i  (err_rx_i),
    .err_seg_i (err_seg_i),
    .rearm_i   (rearm),
    .cap_o     (cap),
    .irq_o     (irq_bus_err_o)
  );

  fc_status #(.PASS_LVL(PASS_LVL)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tec_i     (tec),
    .rec_i     (rec),
    .ewl_i     (ewl),
    .bus_off_i (bus_off),
    .err_st_o  (err_status_o),
    .passive_o (err_passive_o),
    .bus_st_o  (bus_status_o),
    .irq_warn_o(irq_warn_o),
    .irq_pass_o(irq_passive_o)
  );

  fc_regs #(.EWL_RST(EWL_RST)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .wr_i        (reg_wr_i),
    .rd_i        (reg_rd_i),
    .wdata_i     (reg_wdata_i),
    .boff_enter_i(boff_enter),
    .bus_off_i   (bus_off),
    .tec_i       (tec),
    .rec_i       (rec),
    .cap_i       (cap),
    .rdata_o     (reg_rdata_o),
    .mode_o      (reset_mode_o),
    .ewl_o       (ewl),
    .wr_tec_o    (wr_tec),
    .wr_rec_o    (wr_rec),
    .recover_o   (recover),
    .rearm_o     (rearm)
  );
endmodule

// File: tb/can_fault_confine_bench.sv
`timescale 1ns/1ps
module can_fault_confine_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ev = 0, rx = 0, tok = 0, rok = 0, lo = 0, wr = 0, rd = 0;
  logic [1:0] kind = 0;
  logic [4:0] seg = 0;
  logic [2:0] addr = 0;
  logic [7:0] wd = 0, rdata;
  logic       rmode, est, bst, pas, iw, ip, ib;

  int nchk = 0, nerr = 0;
  bit done = 0;

  int m_tec, m_rec, m_ewl;
  bit m_boff, m_mode, m_armed;
  bit [7:0] m_cap;

  always #2 clk = ~clk;

  can_fault_confine u_can_fault_confine (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(ev), .err_kind_i(kind), .err_rx_i(rx),
    .err_seg_i(seg), .tx_ok_i(tok), .rx_ok_i(rok), .listen_only_i(lo),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .reset_mode_o(rmode), .err_status_o(est), .bus_status_o(bst),
    .err_passive_o(pas), .irq_warn_o(iw), .irq_passive_o(ip), .irq_bus_err_o(ib));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_read(bit [2:0] a);
    case (a)
      3'd0: return int'(m_mode);
      3'd1: return m_ewl;
      3'd2: return m_rec;
      3'd3: return m_tec;
      3'd4: return int'(m_cap);
      default: return 0;
    endcase
  endfunction

  function automatic bit f_est(int t, int r, int l); return (t >= l) || (r >= l); endfunction
  function automatic bit f_pas(int t, int r); return (t >= 128) || (r >= 128); endfunction

  // one clock: drive, check read data before the edge, advance model, check outputs after it
  task automatic cyc(string tag, bit e, bit [1:0] k, bit x, bit [4:0] s, bit to, bit ro,
                     bit l, bit w, bit r, bit [2:0] a, bit [7:0] d);
    bit o_est, o_pas, o_boff, benter, recov, cfg, bus_irq;
    int nt, nr;
    ev = e; kind = k; rx = x; seg = s; tok = to; rok = ro; lo = l;
    wr = w; rd = r; addr = a; wd = d;
    @(negedge clk);
    chk({tag, " R10 rdata"}, int'(rdata), m_read(a));
    o_est = f_est(m_tec, m_rec, m_ewl); o_pas = f_pas(m_tec, m_rec); o_boff = m_boff;
    cfg    = w && m_mode;
    benter = e && !x && !m_boff && (m_tec + 8 > 255);
    recov  = w && a == 3'd0 && !d[0] && m_boff;
    bus_irq = 0;
    if (e && m_armed) begin m_cap = {k, x, s}; m_armed = 0; bus_irq = 1; end
    else if (r && a == 3'd4) m_armed = 1;
    nt = m_tec; nr = m_rec;
    if (recov) begin nt = 0; m_boff = 0; end
    else if (benter) begin nt = 128; nr = 0; m_boff = 1; end
    else begin
      if (!m_boff) begin
        if (e && !x) nt = nt + 8;
        else if (!e && to && nt > 0) nt = nt - 1;
        if (!l) begin
          if (e && x) nr = (nr == 255) ? 255 : nr + 1;
          else if (!e && ro && nr > 0) nr = nr - 1;
        end
      end
      if (cfg && a == 3'd3) nt = d;
      if (cfg && a == 3'd2) nr = d;
    end
    if (cfg && a == 3'd1) m_ewl = d;
    if (benter) m_mode = 1; else if (w && a == 3'd0) m_mode = d[0];
    m_tec = nt; m_rec = nr;
    @(posedge clk); #1;
    chk({tag, " R4 reset_mode"}, rmode, m_mode);
    chk({tag, " R4 bus_status"}, bst, m_boff);
    chk({tag, " R6 err_status"}, est, f_est(m_tec, m_rec, m_ewl));
    chk({tag, " R6 err_passive"}, pas, f_pas(m_tec, m_rec));
    chk({tag, " R7 irq_warn"}, iw, (f_est(m_tec, m_rec, m_ewl) != o_est) || (m_boff != o_boff));
    chk({tag, " R7 irq_passive"}, ip, f_pas(m_tec, m_rec) != o_pas);
    chk({tag, " R8 irq_bus_err"}, ib, bus_irq);
  endtask

  task automatic rdr(string tag, bit [2:0] a, bit l = 0);
    cyc(tag, 0, 0, 0, 0, 0, 0, l, 0, (a == 3'd4), a, 0);
  endtask
  task automatic wreg(string tag, bit [2:0] a, bit [7:0] d);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 1, 0, a, d);
  endtask
  task automatic err(string tag, bit x, bit [1:0] k = 0, bit [4:0] s = 0, bit l = 0);
    cyc(tag, 1, k, x, s, 0, 0, l, 0, 0, 3'd5, 0);
  endtask

  initial begin
    bit [15:0] lfsr;
    bit [4:0] segs [12] = '{5'd0, 5'd8, 5'd10, 5'd11, 5'd17, 5'd22, 5'd23, 5'd24,
                            5'd25, 5'd26, 5'd27, 5'd28};
    m_tec = 0; m_rec = 0; m_ewl = 96; m_boff = 0; m_mode = 1; m_armed = 1; m_cap = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    chk("R1 reset_mode", rmode, 1); chk("R1 err_status", est, 0); chk("R1 bus_status", bst, 0);
    chk("R1 err_passive", pas, 0);  chk("R1 irqs", {iw, ip, ib}, 0);
    for (int a = 0; a < 8; a++) rdr("R1", 3'(a));

    // R6/R7: full counter sweeps against several limits
    for (int v = 0; v < 256; v++) begin wreg("R9", 3'd3, 8'(v)); rdr("R6 tec", 3'd3); end
    wreg("R9", 3'd3, 0);
    for (int v = 0; v < 256; v++) begin wreg("R9", 3'd2, 8'(v)); rdr("R6 rec", 3'd2); end
    wreg("R9", 3'd2, 0);
    foreach (segs[i]) begin end
    for (int li = 0; li < 4; li++) begin
      bit [7:0] lim = (li == 0) ? 8'd0 : (li == 1) ? 8'd1 : (li == 2) ? 8'd128 : 8'd255;
      wreg("R9 limit", 3'd1, lim);
      for (int v = 0; v < 256; v += 5) begin wreg("R6", 3'd3, 8'(v)); wreg("R6", 3'd2, 8'(255 - v)); end
    end
    wreg("R9", 3'd1, 8'd96); wreg("R9", 3'd3, 0); wreg("R9", 3'd2, 0);

    // R9: writes ignored outside reset mode
    wreg("R9 leave reset", 3'd0, 0);
    wreg("R9", 3'd1, 8'd5); wreg("R9", 3'd2, 8'd200); wreg("R9", 3'd3, 8'd200);
    rdr("R9 limit kept", 3'd1); rdr("R9 rec kept", 3'd2); rdr("R9 tec kept", 3'd3);

    // R2: steps, floor, precedence of errors over success pulses
    for (int i = 0; i < 5; i++) err("R2 tx err", 0);
    rdr("R2 tec +8", 3'd3);
    for (int i = 0; i < 3; i++) cyc("R2 ok", 0, 0, 0, 0, 1, 1, 0, 0, 0, 3'd5, 0);
    rdr("R2 tec -1", 3'd3);
    for (int i = 0; i < 4; i++) err("R2 rx err", 1);
    cyc("R2 err+ok", 1, 0, 1, 0, 1, 1, 0, 0, 0, 3'd5, 0);
    rdr("R2 rec", 3'd2); rdr("R2 tec", 3'd3);
    for (int i = 0; i < 8; i++) cyc("R2 floor", 0, 0, 0, 0, 0, 1, 0, 0, 0, 3'd5, 0);
    rdr("R2 rec floor", 3'd2);
    wreg("R2", 3'd0, 1); wreg("R2", 3'd2, 8'd254); wreg("R2", 3'd0, 0);
    for (int i = 0; i < 3; i++) err("R2 sat", 1);
    rdr("R2 rec sat 255", 3'd2);
    // R3: listen-only freezes the receive counter
    err("R3 rx err", 1, 0, 0, 1); cyc("R3 rx ok", 0, 0, 0, 0, 0, 1, 1, 0, 0, 3'd5, 0);
    err("R3 tx err", 0, 0, 0, 1);
    rdr("R3 rec frozen", 3'd2, 1); rdr("R3 tec counts", 3'd3, 1);
    // R4/R5: bus-off entry, quiet, recovery
    wreg("R4", 3'd0, 1); wreg("R4", 3'd3, 8'd240); wreg("R4", 3'd0, 0);
    err("R4 tec 248", 0); err("R4 enter", 0);
    rdr("R4 tec 128", 3'd3); rdr("R4 rec 0", 3'd2); rdr("R4 mode forced", 3'd0);
    err("R4 ignored", 0); err("R4 ignored", 1);
    cyc("R4 ok ignored", 0, 0, 0, 0, 1, 1, 0, 0, 0, 3'd5, 0);
    rdr("R4 tec held", 3'd3);
    wreg("R5 recover", 3'd0, 0);
    rdr("R5 tec 0", 3'd3); rdr("R5 mode", 3'd0);

    // R8: capture layout, freeze, re-arm
    rdr("R8 rearm", 3'd4);
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 2; d++)
        foreach (segs[i]) begin
          err("R8 capture", d[0], 2'(k), segs[i]);
          err("R8 frozen", ~d[0], 2'(3 - k), 5'd31 - segs[i]);
          rdr("R8 read", 3'd4);
          if (m_boff) wreg("R5 recover", 3'd0, 0);
        end

    // mixed pseudo-random traffic through bus-off and recovery
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      bit e, w, r, l;
      bit [2:0] a;
      bit [7:0] d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      e = (lfsr[2:0] == 0);
      l = ((i / 300) % 3 == 2);
      r = (lfsr[15:13] == 0);
      a = r ? 3'd4 : 3'(i % 6);
      w = 0; d = lfsr[7:0];
      if (m_boff && lfsr[9]) begin w = 1; a = 3'd0; d = 0; r = 0; end
      else if (i % 97 == 0) begin w = 1; a = 3'd0; d = 1; r = 0; end
      else if (i % 97 == 5) begin w = 1; a = 3'd3; r = 0; end
      else if (i % 97 == 7) begin w = 1; a = 3'(1 + (i % 2)); d = lfsr[7:0] | 8'd8; r = 0; end
      else if (i % 97 == 9) begin w = 1; a = 3'd0; d = 0; r = 0; end
      cyc("R2 mix", e, lfsr[4:3], lfsr[5], lfsr[10:6], lfsr[11] & lfsr[12] & lfsr[13],
          lfsr[12] & lfsr[14], l, w, r, a, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule